// File: doc/BRIEF.md
# Bus Parity Generator and Error Reporter

This block sits beside the bus interface of a 32-bit multiplexed address/data bus agent that can act both as initiator and as target. Every clock it folds the address/data lines and the active-low byte enables into one even-parity bit. On the next clock it drives that bit as the parity line whenever the agent was the source of the bus lines. When the agent was the receiver of a phase that really transferred, it compares the parity bit that arrives one clock later with its own result. A bad address phase pulses the open-drain system-error output. A bad data phase pulses the data-parity-error output. Each pulse comes two clocks after the phase and lasts one clock.

The block also reports errors toward the host interrupt-descriptor queue with a single-cycle event pulse. The pulse carries a 2-bit type code. An event is raised in three cases:
- an address-phase parity error is found;
- the agent, as initiator, reads data with bad parity;
- the agent, as initiator, writes data and the far target answers with the data-parity-error line asserted.

The two output enables only gate the error lines. Events are always reported. The surrounding interface supplies the phase qualifiers: an address-phase strobe, a data-transfer strobe (both handshakes asserted), and flags for "this agent drives AD", "this agent is initiator" and "transaction is a write".

Top module: `pci_parity_guard`

## Requirements
- R1: `par_o` equals the XOR of all bits of `ad_i` and `cbe_n_i` sampled at the previous rising edge, so that AD, C/BE# and PAR together have even parity. `par_oe_o` equals `drive_ad_i` delayed by one clock.
- R2: A received address phase (`addr_phase_i`=1, `drive_ad_i`=0) whose parity does not match `par_i` of the next clock drives `serr_n_o` low for exactly one clock, two clocks after the phase. This happens only if `serr_en_i` is 1 in the parity clock.
- R3: A received data phase (`data_xfer_i`=1, `addr_phase_i`=0, `drive_ad_i`=0) with a parity mismatch drives `perr_n_o` low for exactly one clock, two clocks after the phase. This happens only if `perr_resp_en_i` is 1 in the parity clock.
- R4: No parity check takes place, and no error output or event follows, for a clock in which neither `addr_phase_i` nor `data_xfer_i` is 1, or in which `drive_ad_i` is 1.
- R5: An address-phase error never drives `perr_n_o`, and a data-phase error never drives `serr_n_o`. The two lines are never low in the same clock.
- R6: A data-phase mismatch received while `master_i`=1 and `write_i`=0 raises an event of type 2 (read data parity) in the same clock as the `perr_n_o` slot. This happens whatever the value of `perr_resp_en_i`.
- R7: An address-phase mismatch raises an event of type 1 (address parity) in the same clock as the `serr_n_o` slot. This happens whatever the value of `serr_en_i`.
- R8: After a data phase with `drive_ad_i`, `master_i` and `write_i` all 1, the block samples `perr_n_i` two clocks later. If it is 0, an event of type 3 (target-reported write parity) follows one clock after that.
- R9: `evt_valid_o` is 1 for exactly the clocks in which an event is reported, and `evt_type_o` is 0 otherwise. When a type 1 or 2 event and a type 3 event fall on the same clock, the type 1 or 2 event is reported.
- R10: With `rst_n` low at a rising edge, the next clock shows `par_oe_o`=0, `perr_n_o`=1, `serr_n_o`=1 and `evt_valid_o`=0. Phases captured before the reset produce nothing afterwards.
- R11: A data-phase mismatch received as target (`master_i`=0) drives `perr_n_o` but raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_n_i | input | 4 | Command/byte-enable lines, active low |
| par_i | input | 1 | Parity line as seen on the bus |
| addr_phase_i | input | 1 | This clock is an address phase |
| data_xfer_i | input | 1 | Both handshakes asserted, data moves this clock |
| drive_ad_i | input | 1 | This agent drives AD and C/BE# this clock |
| master_i | input | 1 | This agent is initiator of the current transaction |
| write_i | input | 1 | Current transaction is a write |
| perr_n_i | input | 1 | Data-parity-error line as seen on the bus |
| perr_resp_en_i | input | 1 | Allows driving `perr_n_o` |
| serr_en_i | input | 1 | Allows driving `serr_n_o` |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Enable for driving `par_o` |
| perr_n_o | output | 1 | Data-parity-error output, active low, 1 = released |
| serr_n_o | output | 1 | System-error output, open drain, 1 = released to pull-up |
| evt_valid_o | output | 1 | Single-cycle host error event |
| evt_type_o | output | 2 | Event type: 1 address, 2 read data, 3 target-reported write |

## Verification
Some properties are checked by assertions on every clock:
- each generated parity bit matches the lines of the clock before;
- the error lines fire only when their enable was set and the phase was received rather than driven;
- the two error lines never overlap;
- every type 3 event is preceded by a tracked write phase and a low `perr_n_i`;
- own detections win over write reports.

Other behaviours need the bench's scenarios:
- the exact two- and three-clock latencies;
- the choice between event types for initiator read, target receive and initiator write;
- events still arriving with both enables off;
- flushing of captured phases by a reset in mid-stream.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  typedef enum logic [1:0] {
    EVT_NONE    = 2'd0,
    EVT_ADDR    = 2'd1,
    EVT_RD_DATA = 2'd2,
    EVT_WR_PERR = 2'd3
  } par_evt_e;

  typedef struct packed {
    logic valid;  // a phase transferred
    logic addr;   // it was an address phase
    logic drv;    // this agent was the source
    logic mst;    // this agent is initiator
    logic wr;     // write transaction
  } phase_info_t;

endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            addr_phase_i,
  input  logic            data_xfer_i,
  input  logic            drive_ad_i,
  input  logic            master_i,
  input  logic            write_i,
  output logic            par_o,
  output logic            par_oe_o,
  output phase_info_t     s1_info_o,
  output logic            s1_parity_o
);

  localparam int LINE_W = AD_W + BE_W;

  function automatic logic calc_even_par(input logic [LINE_W-1:0] lines);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < LINE_W; i++) acc = acc ^ lines[i];
    return acc;
  endfunction

  logic        lines_par;
  phase_info_t cur_info;

  assign lines_par      = calc_even_par({ad_i, cbe_n_i});
  assign cur_info.valid = addr_phase_i | data_xfer_i;
  assign cur_info.addr  = addr_phase_i;
  assign cur_info.drv   = drive_ad_i;
  assign cur_info.mst   = master_i;
  assign cur_info.wr    = write_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_o       <= 1'b0;
      par_oe_o    <= 1'b0;
      s1_info_o   <= '0;
      s1_parity_o <= 1'b0;
    end else begin
      par_o       <= lines_par;
      par_oe_o    <= drive_ad_i;
      s1_info_o   <= cur_info;
      s1_parity_o <= lines_par;
    end
  end

  // R1
  par_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (par_o == ^{$past(ad_i), $past(cbe_n_i)}));

  // R1
  par_oe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (par_oe_o == $past(drive_ad_i)));

endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  phase_info_t s1_info_i,
  input  logic        s1_parity_i,
  input  logic        par_i,
  input  logic        perr_resp_en_i,
  input  logic        serr_en_i,
  output logic        perr_n_o,
  output logic        serr_n_o,
  output logic        addr_err_o,
  output logic        rd_err_o,
  output logic        wr_watch_o
);

  logic rx_err;
  logic data_err;

  // only phases received by this agent are checked
  assign rx_err     = s1_info_i.valid & ~s1_info_i.drv & (s1_parity_i ^ par_i);
  assign addr_err_o = rx_err & s1_info_i.addr;
  assign data_err   = rx_err & ~s1_info_i.addr;
  assign rd_err_o   = data_err & s1_info_i.mst & ~s1_info_i.wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_n_o   <= 1'b1;
      serr_n_o   <= 1'b1;
      wr_watch_o <= 1'b0;
    end else begin
      perr_n_o   <= ~(data_err & perr_resp_en_i);
      serr_n_o   <= ~(addr_err_o & serr_en_i);
      wr_watch_o <= s1_info_i.valid & ~s1_info_i.addr & s1_info_i.drv
                    & s1_info_i.mst & s1_info_i.wr;
    end
  end

  // R3
  perr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(perr_resp_en_i));

  // R2
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> ($past(serr_en_i) && $past(s1_info_i.addr)));

  // R4
  no_check_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n_o || !serr_n_o) |-> $past(s1_info_i.valid && !s1_info_i.drv));

  // R5
  no_dual_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!perr_n_o && !serr_n_o));

  // R10
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (perr_n_o && serr_n_o && !wr_watch_o));

endmodule

// File: rtl/pci_err_event.sv
module pci_err_event
  import pci_par_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     addr_err_i,
  input  logic     rd_err_i,
  input  logic     wr_watch_i,
  input  logic     perr_n_i,
  output logic     evt_valid_o,
  output par_evt_e evt_type_o
);

  logic     wr_hit;
  par_evt_e next_type;

  assign wr_hit = wr_watch_i & ~perr_n_i;

  // own detections take precedence over a target report
  always_comb begin
    if (addr_err_i)      next_type = EVT_ADDR;
    else if (rd_err_i)   next_type = EVT_RD_DATA;
    else if (wr_hit)     next_type = EVT_WR_PERR;
    else                 next_type = EVT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid_o <= 1'b0;
      evt_type_o  <= EVT_NONE;
    end else begin
      evt_valid_o <= addr_err_i | rd_err_i | wr_hit;
      evt_type_o  <= next_type;
    end
  end

  // R8
  wr_evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_type_o == EVT_WR_PERR) |-> ($past(wr_watch_i) && !$past(perr_n_i)));

  // R9
  own_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && addr_err_i) |-> (evt_type_o == EVT_ADDR));

  // R9
  evt_type_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid_o |-> (evt_type_o == EVT_NONE));

endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_n_i,
  input  logic            par_i,
  input  logic            addr_phase_i,
  input  logic            data_xfer_i,
  input  logic            drive_ad_i,
  input  logic            master_i,
  input  logic            write_i,
  input  logic            perr_n_i,
  input  logic            perr_resp_en_i,
  input  logic            serr_en_i,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            perr_n_o,
  output logic            serr_n_o,
  output logic            evt_valid_o,
  output logic [1:0]      evt_type_o
);

  phase_info_t s1_info;
  logic        s1_parity;
  logic        addr_err;
  logic        rd_err;
  logic        wr_watch;
  par_evt_e    evt_type;

  pci_par_gen #(.AD_W(AD_W), .BE_W(BE_W)) u_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .ad_i         (ad_i),
    .cbe_n_i      (cbe_n_i),
    .addr_phase_i (addr_phase_i),
    .data_xfer_i  (data_xfer_i),
    .drive_ad_i   (drive_ad_i),
    .master_i     (master_i),
    .write_i      (write_i),
    .par_o        (par_o),
    .par_oe_o     (par_oe_o),
    .s1_info_o    (s1_info),
    .s1_parity_o  (s1_parity)
  );

  pci_par_check u_check (
    .clk            (clk),
    .rst_n          (rst_n),
    .s1_info_i      (s1_info),
    .s1_parity_i    (s1_parity),
    .par_i          (par_i),
    .perr_resp_en_i (perr_resp_en_i),
    .serr_en_i      (serr_en_i),
    .perr_n_o       (perr_n_o),
    .serr_n_o       (serr_n_o),
    .addr_err_o     (addr_err),
    .rd_err_o       (rd_err),
    .wr_watch_o     (wr_watch)
  );

  pci_err_event u_event (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_err_i  (addr_err),
    .rd_err_i    (rd_err),
    .wr_watch_i  (wr_watch),
    .perr_n_i    (perr_n_i),
    .evt_valid_o (evt_valid_o),
    .evt_type_o  (evt_type)
  );

  assign evt_type_o = evt_type;

  // R6
  rd_evt_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_type_o == 2'd2) |-> serr_n_o);

  // R11
  target_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && s1_info.valid && !s1_info.mst && !s1_info.addr) |->
      (evt_type_o != 2'd2));

endmodule

// File: tb/test_pci_parity_guard.sv
`timescale 1ns/1ps
module test_pci_parity_guard;

  typedef struct {
    logic        rst;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        par, ap, dx, drv, mst, wr, pn, pen, sen;
  } stim_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, par_i, addr_phase_i, data_xfer_i, drive_ad_i, master_i, write_i;
  logic        perr_n_i, perr_resp_en_i, serr_en_i;
  logic [31:0] ad_i;
  logic [3:0]  cbe_n_i;
  logic        par_o, par_oe_o, perr_n_o, serr_n_o, evt_valid_o;
  logic [1:0]  evt_type_o;

  pci_parity_guard i_pci_parity_guard (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i), .par_i(par_i),
    .addr_phase_i(addr_phase_i), .data_xfer_i(data_xfer_i), .drive_ad_i(drive_ad_i),
    .master_i(master_i), .write_i(write_i), .perr_n_i(perr_n_i),
    .perr_resp_en_i(perr_resp_en_i), .serr_en_i(serr_en_i), .par_o(par_o),
    .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .serr_n_o(serr_n_o),
    .evt_valid_o(evt_valid_o), .evt_type_o(evt_type_o)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  stim_t nx, h0, h1, h2;
  bit    have_exp = 0;
  logic  e_par, e_oe, e_perr, e_serr;
  logic [1:0] e_type;
  logic  o_par, o_oe, o_perr, o_serr, o_val;
  logic [1:0] o_type;

  function automatic logic ref_par(logic [31:0] a, logic [3:0] b);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++)  ones += b[i];
    return logic'(ones % 2);
  endfunction

  function automatic logic vld(stim_t s);
    return s.rst && (s.ap || s.dx);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic rx;
    @(negedge clk);
    o_par = par_o; o_oe = par_oe_o; o_perr = perr_n_o; o_serr = serr_n_o;
    o_val = evt_valid_o; o_type = evt_type_o;
    if (have_exp) begin
      chk("R1 oe", o_oe, e_oe);
      if (e_oe) chk("R1 par", o_par, e_par);
      chk("R3 perr", o_perr, e_perr);
      chk("R2 serr", o_serr, e_serr);
      chk("R9 valid", o_val, e_type != 2'd0);
      case (e_type)
        2'd1: chk("R7 type", o_type, e_type);
        2'd2: chk("R6 type", o_type, e_type);
        2'd3: chk("R8 type", o_type, e_type);
        default: chk("R9 type", o_type, e_type);
      endcase
    end
    rst_n = nx.rst; ad_i = nx.ad; cbe_n_i = nx.cbe; par_i = nx.par;
    addr_phase_i = nx.ap; data_xfer_i = nx.dx; drive_ad_i = nx.drv;
    master_i = nx.mst; write_i = nx.wr; perr_n_i = nx.pn;
    perr_resp_en_i = nx.pen; serr_en_i = nx.sen;
    h2 = h1; h1 = h0; h0 = nx;
    if (!h0.rst) begin
      e_par = 1'b0; e_oe = 1'b0; e_perr = 1'b1; e_serr = 1'b1; e_type = 2'd0;
    end else begin
      e_par  = ref_par(h0.ad, h0.cbe);
      e_oe   = h0.drv;
      rx     = vld(h1) && !h1.drv && (ref_par(h1.ad, h1.cbe) != h0.par);
      e_perr = !(rx && !h1.ap && h0.pen);
      e_serr = !(rx && h1.ap && h0.sen);
      if (rx && h1.ap) e_type = 2'd1;
      else if (rx && h1.mst && !h1.wr) e_type = 2'd2;
      else if (vld(h2) && h1.rst && !h2.ap && h2.drv && h2.mst && h2.wr && !h0.pn)
        e_type = 2'd3;
      else e_type = 2'd0;
    end
    have_exp = 1;
  endtask

  task automatic idle();
    nx.ad = $urandom; nx.cbe = 4'($urandom);
    nx.ap = 0; nx.dx = 0; nx.drv = 0; nx.mst = 0; nx.wr = 0;
    nx.pn = 1; nx.pen = 1; nx.sen = 1;
    nx.par = ref_par(h0.ad, h0.cbe);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) begin idle(); tick(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    h0 = '{rst: 0, ad: 0, cbe: 0, default: 0};
    h1 = h0; h2 = h0; nx = h0;
    idle(); nx.rst = 0;
    for (int i = 0; i < 3; i++) tick();
    // R10: outputs released after reset
    tick();
    chk("R10 reset", {o_oe, o_perr, o_serr, o_val}, 4'b0110);
    nx.rst = 1;
    flush();

    // R4: bad parity on a clock with no transfer
    idle(); nx.drv = 0; tick();
    idle(); nx.par = ~nx.par; tick();
    idle(); tick();
    chk("R4 idle", {o_perr, o_serr, o_val}, 3'b110);
    // R4: bad parity on a driven data phase
    idle(); nx.dx = 1; nx.drv = 1; tick();
    idle(); nx.par = ~nx.par; tick();
    idle(); tick();
    chk("R4 driven", {o_perr, o_serr, o_val}, 3'b110);
    flush();

    // R11: target receives bad write data
    idle(); nx.dx = 1; nx.wr = 1; tick();
    idle(); nx.par = ~nx.par; tick();
    idle(); tick();
    chk("R11 perr", o_perr, 1'b0);
    chk("R11 noevt", o_val, 1'b0);
    flush();

    // R6: initiator read error with response disabled
    idle(); nx.dx = 1; nx.mst = 1; tick();
    idle(); nx.par = ~nx.par; nx.pen = 0; tick();
    idle(); tick();
    chk("R6 perr off", o_perr, 1'b1);
    chk("R6 type", o_type, 2'd2);
    flush();

    // R7 and R5: address error with system-error output disabled
    idle(); nx.ap = 1; tick();
    idle(); nx.par = ~nx.par; nx.sen = 0; tick();
    idle(); tick();
    chk("R7 type", o_type, 2'd1);
    chk("R5 lines", {o_perr, o_serr}, 2'b11);
    flush();

    // R8: target reports error on initiator write
    idle(); nx.dx = 1; nx.drv = 1; nx.mst = 1; nx.wr = 1; tick();
    idle(); tick();
    idle(); nx.pn = 0; tick();
    idle(); tick();
    chk("R8 type", o_type, 2'd3);
    flush();

    // R9: write report collides with own address error
    idle(); nx.dx = 1; nx.drv = 1; nx.mst = 1; nx.wr = 1; tick();
    idle(); nx.ap = 1; tick();
    idle(); nx.par = ~nx.par; nx.pn = 0; tick();
    idle(); tick();
    chk("R9 prio", o_type, 2'd1);
    chk("R2 serr", o_serr, 1'b0);
    idle(); tick();
    chk("R2 one clock", o_serr, 1'b1);
    flush();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      nx.rst = ($urandom % 300) != 0;
      nx.ad  = $urandom; nx.cbe = 4'($urandom);
      nx.ap  = ($urandom % 6) == 0;
      nx.dx  = !nx.ap && ($urandom % 2);
      nx.drv = $urandom % 2; nx.mst = $urandom % 2; nx.wr = $urandom % 2;
      nx.pn  = ($urandom % 3) != 0;
      nx.pen = ($urandom % 5) != 0; nx.sen = ($urandom % 5) != 0;
      nx.par = ref_par(h0.ad, h0.cbe) ^ (($urandom % 4) == 0);
      tick();
    end
    nx.rst = 1;
    flush();

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule